// File: doc/BRIEF.md
# Timer Register Interface

This block is the processor-side front end of a three-channel interval timer. A processor writes command bytes to one control address and count bytes to one data address per channel. It reads count and status bytes back through the same 8-bit bus. The block turns command bytes into per-channel settings: an operating mode, a BCD flag and a byte-access pattern. It assembles the initial count from one or two bytes and hands it to the counting logic with a one-cycle strobe.

On the read side, the block returns bytes of each channel's live count. It can also freeze a count on command, so that a 16-bit value read as two bytes is self-consistent while the counter keeps running. A status byte can be captured for one or more channels at once through a multi-channel read-back command. The counting elements are outside this block: each supplies its live count, its output level and a flag that shows a written count has not yet reached the counting element.

Top module: `tmr_regif`

## Requirements
- R1: A write to address 3 whose bits [7:6] name channel c (0..2) and whose bits [5:4] are not 00 stores bits [5:0] as that channel's configuration and pulses `cfg_strobe[c]` high for exactly the following cycle; other channels keep their configuration.
- R2: `cfg_mode` for a channel reports its stored bits [3:1] as a 3-bit mode, except that codes 6 and 7 are reported as 2 and 3; `cfg_bcd` reports stored bit 0.
- R3: Access code (bits [5:4]) 01 loads count {8'h00, byte} from one data write, 10 loads {byte, 8'h00}, 11 takes a low byte then a high byte; in the cycle after the completing write `init_strobe[c]` pulses with `init_value` holding the count, and `armed[c]` becomes 1.
- R4: Data writes to a channel that has received no configuration since reset are ignored: no strobe, `armed` stays 0.
- R5: A configuration write clears that channel's `armed` and resets both its write and read byte toggles, so the next data write and the next count read each address the low byte under access 11.
- R6: With nothing latched, a read of data address c returns the live count's low byte (access 01), high byte (access 10), or low then high on alternate reads (access 11).
- R7: A latch command (address 3, bits [5:4] = 00, bits [7:6] = c) captures the live count; reads then return bytes of the captured value until it has been fully read (one read for access 01 or 10, two for 11), after which reads return the live count.
- R8: A count latch command for a channel whose captured count has not been fully read is ignored.
- R9: A status byte holds the OUT level in bit 7, the load-pending flag in bit 6, and the stored configuration bits [5:0] in bits 5..0.
- R10: A write to address 3 with bits [7:6] = 11 is a read-back command: bits 1, 2 and 3 select channels 0, 1 and 2; bit 5 = 0 latches their counts and bit 4 = 0 latches their status. A latched status is returned by the next read ahead of any count byte, and a status latch on a channel whose status is still held is ignored.
- R11: After reset no channel is configured or armed, all strobes are 0, the stored configuration is 6'b110000 (access 11, mode 0, binary), and reads of address 3 return 8'h00 with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | 0..2 channel data, 3 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| ch_count | input | NUM_CH*16 | Live count of each channel |
| ch_out | input | NUM_CH | OUT level of each channel |
| ch_pending | input | NUM_CH | Written count not yet loaded, per channel |
| cfg_mode | output | NUM_CH*3 | Effective operating mode per channel |
| cfg_bcd | output | NUM_CH | BCD counting select per channel |
| cfg_strobe | output | NUM_CH | One-cycle pulse after a configuration write |
| init_value | output | NUM_CH*16 | Assembled initial count per channel |
| init_strobe | output | NUM_CH | One-cycle pulse when an initial count is complete |
| armed | output | NUM_CH | Configuration and count both written |

## Verification
The bench builds the block with NUM_CH = 3, the largest value that the control address allows. At this value every select bit of the read-back mask maps to a real channel, and a single read-back command can freeze counts and status on all three channels at once. Each channel gets a different access pattern (low-then-high, low only, high only), so all three byte-selection paths run side by side against live counts that move at different rates. A behavioural model of latches and toggles predicts every read byte and strobe on every cycle, including the cases where a latch or status command is ignored.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int BYTE_W    = 8;
    localparam int CNT_W     = 16;
    localparam int MODE_W    = 3;
    localparam int CFG_W     = 6;
    localparam logic [1:0] CTRL_ADDR = 2'd3;
    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [CFG_W-1:0] CFG_RESET = 6'b110000;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } access_e;

    typedef struct packed {
        logic [1:0]        sel;
        access_e           acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } ctrl_word_t;

    typedef struct packed {
        logic cfg_we;
        logic cnt_latch;
        logic sts_latch;
        logic data_we;
        logic rd_hit;
    } chan_cmd_t;

    typedef struct packed {
        logic [CFG_W-1:0]  cfg;
        logic              configured;
        logic              armed;
        logic              wr_tog;
        logic              rd_tog;
        logic [BYTE_W-1:0] low_hold;
        logic              cnt_lat;
        logic [CNT_W-1:0]  cnt_hold;
        logic              sts_lat;
        logic [BYTE_W-1:0] sts_hold;
        logic [CNT_W-1:0]  init_val;
        logic              init_stb;
        logic              cfg_stb;
    } chan_state_t;

    function automatic logic [MODE_W-1:0] eff_mode(input logic [MODE_W-1:0] m);
        return m[1] ? {1'b0, m[1:0]} : m;
    endfunction

    function automatic logic want_high(input access_e a, input logic tog);
        return (a == ACC_HI) || ((a == ACC_LOHI) && tog);
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v, input logic hi);
        return hi ? v[CNT_W-1 -: BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output chan_cmd_t         cmd [NUM_CH]
);

    ctrl_word_t cw;
    logic       ctrl_wr;
    logic       readback;

    assign cw       = ctrl_word_t'(bus_wdata);
    assign ctrl_wr  = bus_wr && (bus_addr == CTRL_ADDR);
    assign readback = ctrl_wr && (cw.sel == SEL_READBACK);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic targeted;
        logic rb_pick;
        assign targeted = ctrl_wr && (cw.sel == 2'(c));
        assign rb_pick  = readback && bus_wdata[c+1];

        always_comb begin
            cmd[c].cfg_we    = targeted && (cw.acc != ACC_LATCH);
            cmd[c].cnt_latch = (targeted && (cw.acc == ACC_LATCH))
                             || (rb_pick && !bus_wdata[5]);
            cmd[c].sts_latch = rb_pick && !bus_wdata[4];
            cmd[c].data_we   = bus_wr && (bus_addr == 2'(c));
            cmd[c].rd_hit    = bus_rd && (bus_addr == 2'(c));
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cmd_t         cmd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    input  logic              out_lvl,
    input  logic              pending,
    output logic [BYTE_W-1:0] rbyte,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic              cfg_stb,
    output logic [CNT_W-1:0]  init_val,
    output logic              init_stb,
    output logic              armed
);

    chan_state_t st_q, st_d;
    access_e     acc;
    logic [BYTE_W-1:0] live_status;
    logic [CNT_W-1:0]  rd_src;

    assign acc         = access_e'(st_q.cfg[5:4]);
    assign live_status = {out_lvl, pending, st_q.cfg};
    assign rd_src      = st_q.cnt_lat ? st_q.cnt_hold : live_count;

    always_comb begin
        if (st_q.sts_lat) rbyte = st_q.sts_hold;
        else              rbyte = pick_byte(rd_src, want_high(acc, st_q.rd_tog));
    end

    always_comb begin
        st_d          = st_q;
        st_d.init_stb = 1'b0;
        st_d.cfg_stb  = 1'b0;

        if (cmd.cfg_we) begin
            st_d.cfg        = wdata[CFG_W-1:0];
            st_d.configured = 1'b1;
            st_d.armed      = 1'b0;
            st_d.wr_tog     = 1'b0;
            st_d.rd_tog     = 1'b0;
            st_d.cfg_stb    = 1'b1;
        end else if (cmd.data_we && st_q.configured) begin
            unique case (acc)
                ACC_LO: begin
                    st_d.init_val = {{BYTE_W{1'b0}}, wdata};
                    st_d.init_stb = 1'b1;
                end
                ACC_HI: begin
                    st_d.init_val = {wdata, {BYTE_W{1'b0}}};
                    st_d.init_stb = 1'b1;
                end
                ACC_LOHI: begin
                    if (!st_q.wr_tog) begin
                        st_d.low_hold = wdata;
                        st_d.wr_tog   = 1'b1;
                    end else begin
                        st_d.init_val = {wdata, st_q.low_hold};
                        st_d.init_stb = 1'b1;
                        st_d.wr_tog   = 1'b0;
                    end
                end
                default: ;
            endcase
            if (st_d.init_stb) st_d.armed = 1'b1;
        end

        if (cmd.cnt_latch && !st_q.cnt_lat) begin
            st_d.cnt_hold = live_count;
            st_d.cnt_lat  = 1'b1;
        end
        if (cmd.sts_latch && !st_q.sts_lat) begin
            st_d.sts_hold = live_status;
            st_d.sts_lat  = 1'b1;
        end

        if (cmd.rd_hit) begin
            if (st_q.sts_lat) begin
                st_d.sts_lat = 1'b0;
            end else if (acc == ACC_LOHI) begin
                st_d.rd_tog = !st_q.rd_tog;
                if (st_q.rd_tog) st_d.cnt_lat = 1'b0;
            end else begin
                st_d.cnt_lat = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode     = eff_mode(st_q.cfg[3:1]);
    assign bcd      = st_q.cfg[0];
    assign cfg_stb  = st_q.cfg_stb;
    assign init_val = st_q.init_val;
    assign init_stb = st_q.init_stb;
    assign armed    = st_q.armed;

endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] chan_byte [NUM_CH],
    output logic [BYTE_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == 2'(c)) rdata = chan_byte[c];
        end
    end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [1:0]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_CH*16-1:0]    ch_count,
    input  logic [NUM_CH-1:0]       ch_out,
    input  logic [NUM_CH-1:0]       ch_pending,
    output logic [NUM_CH*3-1:0]     cfg_mode,
    output logic [NUM_CH-1:0]       cfg_bcd,
    output logic [NUM_CH-1:0]       cfg_strobe,
    output logic [NUM_CH*16-1:0]    init_value,
    output logic [NUM_CH-1:0]       init_strobe,
    output logic [NUM_CH-1:0]       armed
);

    chan_cmd_t         cmd       [NUM_CH];
    logic [BYTE_W-1:0] chan_byte [NUM_CH];

    tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .cmd       (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmr_chan_regs u_regs (
            .clk        (clk),
            .rst        (rst),
            .cmd        (cmd[c]),
            .wdata      (bus_wdata),
            .live_count (ch_count[c*CNT_W +: CNT_W]),
            .out_lvl    (ch_out[c]),
            .pending    (ch_pending[c]),
            .rbyte      (chan_byte[c]),
            .mode       (cfg_mode[c*MODE_W +: MODE_W]),
            .bcd        (cfg_bcd[c]),
            .cfg_stb    (cfg_strobe[c]),
            .init_val   (init_value[c*CNT_W +: CNT_W]),
            .init_stb   (init_strobe[c]),
            .armed      (armed[c])
        );
    end

    tmr_read_mux #(.NUM_CH(NUM_CH)) u_mux (
        .bus_addr  (bus_addr),
        .chan_byte (chan_byte),
        .rdata     (bus_rdata)
    );

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
    parameter int NUM_CH = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [1:0]           bus_addr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [NUM_CH*3-1:0]  cfg_mode,
    input logic [NUM_CH-1:0]    cfg_strobe,
    input logic [NUM_CH-1:0]    init_strobe,
    input logic [NUM_CH-1:0]    armed
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        // R1: a configuration strobe is only ever caused by a matching control write
        assert_cfg_pulse_R1: assert property (@(posedge clk) disable iff (rst)
            cfg_strobe[c] |-> $past(bus_wr && (bus_addr == 2'd3)
                                    && (bus_wdata[7:6] == 2'(c))
                                    && (bus_wdata[5:4] != 2'b00)));

        // R2: modes 6 and 7 never appear at the output
        assert_mode_alias_R2: assert property (@(posedge clk) disable iff (rst)
            cfg_mode[c*3+1] |-> !cfg_mode[c*3+2]);

        // R3: arming coincides with a completed initial count
        assert_arm_load_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(armed[c]) |-> init_strobe[c]);

        // R5: a fresh configuration leaves the channel disarmed
        assert_cfg_disarm_R5: assert property (@(posedge clk) disable iff (rst)
            cfg_strobe[c] |-> !armed[c]);
    end

    // R11: control address reads as zero
    assert_ctrl_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == 2'd3)) |-> (bus_rdata == 8'h00));

endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .cfg_mode    (cfg_mode),
    .cfg_strobe  (cfg_strobe),
    .init_strobe (init_strobe),
    .armed       (armed)
);

// File: tb/sim_tmr_regif.sv
module sim_tmr_regif;

    localparam int NCH = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    wire  [7:0] bus_rdata;
    logic [15:0] live [NCH];
    logic [NCH-1:0] ch_out = '0, ch_pending = '0;
    wire [NCH*16-1:0] ch_count = {live[2], live[1], live[0]};
    wire [NCH*3-1:0]  cfg_mode;
    wire [NCH-1:0]    cfg_bcd, cfg_strobe, init_strobe, armed;
    wire [NCH*16-1:0] init_value;

    tmr_regif #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_count(ch_count), .ch_out(ch_out), .ch_pending(ch_pending),
        .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cfg_strobe(cfg_strobe),
        .init_value(init_value), .init_strobe(init_strobe), .armed(armed)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // stub counting elements: each channel moves at its own rate
    initial begin
        live[0] = 16'hF00D;
        live[1] = 16'h8421;
        live[2] = 16'h0300;
    end
    always @(negedge clk) begin
        live[0] <= live[0] - 16'd1;
        live[1] <= live[1] - 16'd3;
        live[2] <= live[2] + 16'd7;
    end

    // reference model
    logic [5:0]  m_cfg   [NCH];
    bit          m_cfgd  [NCH], m_arm [NCH], m_wtog [NCH], m_rtog [NCH];
    bit          m_clat  [NCH], m_slat [NCH];
    logic [7:0]  m_low   [NCH], m_shold [NCH];
    logic [15:0] m_chold [NCH], m_ival [NCH];
    bit          m_cstb  [NCH], m_istb [NCH];

    logic        s_w, s_r, s_rst;
    logic [1:0]  s_a;
    logic [7:0]  s_d;
    logic [15:0] s_live [NCH];
    logic [NCH-1:0] s_out, s_pend;

    function automatic logic [7:0] exp_rd();
        logic [15:0] src;
        int acc;
        bit hi;
        if (bus_addr == 2'd3) return 8'h00;
        if (m_slat[bus_addr]) return m_shold[bus_addr];
        src = m_clat[bus_addr] ? m_chold[bus_addr] : live[bus_addr];
        acc = int'(m_cfg[bus_addr][5:4]);
        hi  = (acc == 2) || (acc == 3 && m_rtog[bus_addr]);
        return hi ? src[15:8] : src[7:0];
    endfunction

    always @(posedge clk) begin
        s_w = bus_wr; s_r = bus_rd; s_a = bus_addr; s_d = bus_wdata; s_rst = rst;
        for (int c = 0; c < NCH; c++) s_live[c] = live[c];
        s_out = ch_out; s_pend = ch_pending;
        #1;
        for (int c = 0; c < NCH; c++) begin
            m_cstb[c] = 0;
            m_istb[c] = 0;
        end
        if (s_rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_cfg[c] = 6'h30; m_cfgd[c] = 0; m_arm[c] = 0; m_wtog[c] = 0;
                m_rtog[c] = 0; m_clat[c] = 0; m_slat[c] = 0; m_ival[c] = 0;
            end
        end else begin
            if (s_w && s_a == 2'd3) begin
                if (s_d[7:6] == 2'd3) begin
                    for (int c = 0; c < NCH; c++) begin
                        if (s_d[c+1]) begin
                            if (!s_d[5] && !m_clat[c]) begin m_clat[c] = 1; m_chold[c] = s_live[c]; end
                            if (!s_d[4] && !m_slat[c]) begin
                                m_slat[c] = 1;
                                m_shold[c] = {s_out[c], s_pend[c], m_cfg[c]};
                            end
                        end
                    end
                end else if (int'(s_d[7:6]) < NCH) begin
                    int c;
                    c = int'(s_d[7:6]);
                    if (s_d[5:4] == 2'b00) begin
                        if (!m_clat[c]) begin m_clat[c] = 1; m_chold[c] = s_live[c]; end
                    end else begin
                        m_cfg[c] = s_d[5:0]; m_cfgd[c] = 1; m_arm[c] = 0;
                        m_wtog[c] = 0; m_rtog[c] = 0; m_cstb[c] = 1;
                    end
                end
            end
            if (s_w && int'(s_a) < NCH && m_cfgd[s_a]) begin
                int c;
                c = int'(s_a);
                case (m_cfg[c][5:4])
                    2'b01: begin m_ival[c] = {8'h00, s_d}; m_istb[c] = 1; end
                    2'b10: begin m_ival[c] = {s_d, 8'h00}; m_istb[c] = 1; end
                    default: begin
                        if (!m_wtog[c]) begin m_low[c] = s_d; m_wtog[c] = 1; end
                        else begin m_ival[c] = {s_d, m_low[c]}; m_istb[c] = 1; m_wtog[c] = 0; end
                    end
                endcase
                if (m_istb[c]) m_arm[c] = 1;
            end
            if (s_r && int'(s_a) < NCH) begin
                int c;
                c = int'(s_a);
                if (m_slat[c]) m_slat[c] = 0;
                else if (m_cfg[c][5:4] == 2'b11) begin
                    if (m_rtog[c]) m_clat[c] = 0;
                    m_rtog[c] = !m_rtog[c];
                end else m_clat[c] = 0;
            end
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        #2;
        if (!rst && !finished) begin
            for (int c = 0; c < NCH; c++) begin
                int m;
                m = int'(m_cfg[c][3:1]);
                if (m >= 6) m = m - 4;
                chk("R1 cfg_strobe", int'(cfg_strobe[c]), int'(m_cstb[c]));
                chk("R2 cfg_mode", int'(cfg_mode[c*3 +: 3]), m);
                chk("R2 cfg_bcd", int'(cfg_bcd[c]), int'(m_cfg[c][0]));
                chk("R3/R4 init_strobe", int'(init_strobe[c]), int'(m_istb[c]));
                chk("R3/R4/R5 armed", int'(armed[c]), int'(m_arm[c]));
                if (m_istb[c]) chk("R3 init_value", int'(init_value[c*16 +: 16]), int'(m_ival[c]));
            end
            if (bus_rd) begin
                if (bus_addr == 2'd3)       chk("R11 ctrl read", int'(bus_rdata), int'(exp_rd()));
                else if (m_slat[bus_addr])  chk("R9/R10 status", int'(bus_rdata), int'(exp_rd()));
                else if (m_clat[bus_addr])  chk("R7/R8 latched", int'(bus_rdata), int'(exp_rd()));
                else                        chk("R5/R6 live", int'(bus_rdata), int'(exp_rd()));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        #3;
        // R11 reset state
        chk("R11 armed", int'(armed), 0);
        chk("R11 strobes", int'({cfg_strobe, init_strobe}), 0);
        rd(2'd0); rd(2'd0);                // R6 live, default access low/high
        rd(2'd3);                          // R11
        wr(2'd1, 8'h12); idle(2);          // R4 ignored before configuration
        wr(2'd3, 8'hE2); rd(2'd0);         // R11 reset configuration via status
        wr(2'd3, 8'h34);                   // R1 ch0 mode 2, low/high
        wr(2'd0, 8'h34); wr(2'd0, 8'h12);  // R3 -> 1234
        wr(2'd3, 8'h5B); wr(2'd1, 8'hAB);  // R3 ch1 low only, mode 5, BCD
        wr(2'd3, 8'hAE); wr(2'd2, 8'hCD);  // R2 mode 7 -> 3, R3 high only
        rd(2'd0); rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd2);   // R6
        wr(2'd3, 8'h00); idle(3);          // R7 latch ch0
        rd(2'd0); idle(2);
        wr(2'd3, 8'h00); idle(2);          // R8 ignored
        rd(2'd0); rd(2'd0); rd(2'd0);      // R7 released, live again
        wr(2'd3, 8'h40); idle(2); rd(2'd1); rd(2'd1);  // R7 single byte
        ch_out = 3'b101; ch_pending = 3'b010;
        wr(2'd3, 8'hCE); idle(2);          // R10 count+status all channels
        rd(2'd0); rd(2'd0); rd(2'd0); rd(2'd0);
        rd(2'd2); rd(2'd2); rd(2'd2);
        ch_out = 3'b010; ch_pending = 3'b000;
        wr(2'd3, 8'hE4); idle(1);          // R10 status ch1 again: ignored
        rd(2'd1); rd(2'd1); rd(2'd1);
        wr(2'd3, 8'hE4); rd(2'd1); rd(2'd1);  // R9 fresh status
        wr(2'd3, 8'h36); wr(2'd0, 8'h78);  // R5 half write then reconfigure
        rd(2'd0);
        wr(2'd3, 8'h30); rd(2'd0); rd(2'd0);
        wr(2'd0, 8'h11); wr(2'd0, 8'h22);  // R5 -> 2211
        wr(2'd3, 8'h1C);                   // R2 mode 6 -> 2
        wr(2'd3, 8'hF0); idle(2);          // R10 with empty selection
        wr(2'd3, 8'hDE); idle(1);          // R10 count only, all
        rd(2'd0); rd(2'd1); rd(2'd2); rd(2'd3);
        idle(4);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule